// File: doc/BRIEF.md
# Aliased Miscellaneous Status Register

This block is a single 64-bit control and status word behind a small register-bus slave port. Software reaches the word through three consecutive word addresses. One address reads and writes the word directly. The other two are write aliases that change the stored value in one bus cycle, so no read-modify-write sequence is needed. Only the upper 16 bits hold state. The lower 48 bits always read back as zero.

The most significant bit drives a level interrupt line toward an interrupt hub. A parameter picks one of two variants. In the AND/OR variant the aliases combine the write data with the stored word by AND and by OR. In the clear/OR variant the first alias zeroes the word and the second ORs data into it. The two variants also sit at different base addresses.

Every access carries a byte count, and only full 8-byte accesses have any effect. The word address is the byte address shifted right by three, so the low three address bits are ignored. The word is big-endian: bus bit 63 is the most significant bit.

Top module: `misc_stat_reg`

## Requirements
- R1: After reset, the stored word is zero, `irq` is low and `rsp_valid` is low. A direct read after reset returns zero.
- R2: An 8-byte write to the direct word address stores the write data ANDed with 0xFFFF_0000_0000_0000. The direct address is word 0x4020 in the AND/OR variant (`VARIANT`=0) and word 0x6080 in the clear/OR variant (`VARIANT`=1). A direct read returns the stored word, so bits 47:0 are always zero.
- R3: In the AND/OR variant, an 8-byte write to word base+1 stores (stored AND write data), masked to the upper 16 bits.
- R4: In both variants, an 8-byte write to word base+2 stores (stored OR write data), masked to the upper 16 bits.
- R5: In the clear/OR variant, an 8-byte write to word base+1 stores zero, whatever the write data.
- R6: Every request with `req_valid` high gets `rsp_valid` high in the next cycle, and in no other cycle. `rsp_rdata` carries the stored word only for an 8-byte read of the direct address. It is zero for writes, for alias reads and for reads of any other address.
- R7: A write to any word address other than the three the variant implements leaves the stored word and `irq` unchanged.
- R8: A request whose `req_size` (a byte count) is not 8 is ignored: the stored word does not change and `rsp_rdata` is zero. In its response cycle `rsp_err` is 1. `rsp_err` is 0 in every other response.
- R9: `irq` equals bit 63 of the stored word. It changes in the cycle after the write that changes that bit, and it holds its level between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address; the word address is bits 31:3 |
| req_size | input | 4 | Access size in bytes; only 8 is valid |
| req_wdata | input | 64 | Write data, bit 63 most significant |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 64 | Read data for the response |
| rsp_err | output | 1 | Response flag for a bad access size |
| irq | output | 1 | Level interrupt, equal to stored bit 63 |

## Verification
Every result of this block is due exactly one clock after its request: the response strobe, the read data, the error flag, the updated word and the new interrupt level. The bench drives each request on a falling edge and samples all four outputs on the next falling edge. At that point one rising edge has captured the request and the registered outputs have settled. Because a read returns the word as it was before that cycle, expected read data comes from the bench model before the model applies the same request. An instance of each variant shares the bus, so every access that one variant implements also reaches the other as an unimplemented address.

// File: rtl/misc_stat_pkg.sv
package misc_stat_pkg;

  // Alias flavour selected per instance
  typedef enum logic [0:0] {
    VAR_AND_OR = 1'b0,
    VAR_CLR_OR = 1'b1
  } alias_variant_e;

  // Write operation produced by the address decoder
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_AND   = 3'd2,
    OP_CLEAR = 3'd3,
    OP_SET   = 3'd4
  } wr_op_e;

  // Word address of the direct register for each variant
  function automatic logic [31:0] base_word(alias_variant_e v);
    return (v == VAR_AND_OR) ? 32'h0000_4020 : 32'h0000_6080;
  endfunction

endpackage

// File: rtl/misc_stat_decode.sv
module misc_stat_decode
  import misc_stat_pkg::*;
#(
  parameter int             ADDR_W       = 32,
  parameter int             SIZE_W       = 4,
  parameter int             ACCESS_BYTES = 8,
  parameter alias_variant_e VARIANT      = VAR_AND_OR
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              size_ok,
  output wr_op_e            wr_op,
  output logic              wr_ev,
  output logic              rd_dir_ev,
  output logic              unimpl_ev
);

  localparam int              WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] BASE   = WORD_W'(base_word(VARIANT));
  localparam logic [WORD_W-1:0] ALIAS1 = BASE + WORD_W'(1);
  localparam logic [WORD_W-1:0] ALIAS2 = BASE + WORD_W'(2);

  logic [WORD_W-1:0] word;
  logic [2:0]        unused_lsb;
  logic              good;
  logic              hit_dir;
  logic              hit_a1;
  logic              hit_a2;
  wr_op_e            alias1_op;

  assign word       = req_addr[ADDR_W-1:3];
  assign unused_lsb = req_addr[2:0];

  assign size_ok = (req_size == SIZE_W'(ACCESS_BYTES));
  assign good    = req_valid && size_ok;

  assign hit_dir = (word == BASE);
  assign hit_a1  = (word == ALIAS1);
  assign hit_a2  = (word == ALIAS2);

  generate
    if (VARIANT == VAR_AND_OR) begin : g_and_alias
      assign alias1_op = OP_AND;
    end else begin : g_clear_alias
      assign alias1_op = OP_CLEAR;
    end
  endgenerate

  always_comb begin
    wr_op = OP_NONE;
    if (good && req_write) begin
      if (hit_dir)     wr_op = OP_LOAD;
      else if (hit_a1) wr_op = alias1_op;
      else if (hit_a2) wr_op = OP_SET;
    end
  end

  assign wr_ev     = (wr_op != OP_NONE);
  assign rd_dir_ev = good && !req_write && hit_dir;
  assign unimpl_ev = good && !(hit_dir || hit_a1 || hit_a2);

endmodule

// File: rtl/misc_stat_store.sv
module misc_stat_store
  import misc_stat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMPL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  wr_op_e            wr_op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              irq
);

  localparam int              PAD_W     = DATA_W - IMPL_W;
  localparam logic [DATA_W-1:0] KEEP_MASK = {{IMPL_W{1'b1}}, {PAD_W{1'b0}}};

  // New word for one write operation, trimmed to the implemented bits
  function automatic logic [DATA_W-1:0] merge(wr_op_e op,
                                               logic [DATA_W-1:0] cur,
                                               logic [DATA_W-1:0] wd);
    logic [DATA_W-1:0] raw;
    case (op)
      OP_LOAD:  raw = wd;
      OP_AND:   raw = cur & wd;
      OP_CLEAR: raw = '0;
      OP_SET:   raw = cur | wd;
      default:  raw = cur;
    endcase
    return raw & KEEP_MASK;
  endfunction

  logic [DATA_W-1:0] nxt;

  assign nxt = merge(wr_op, value, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      irq   <= 1'b0;
    end else if (wr_ev) begin
      value <= nxt;
      irq   <= nxt[DATA_W-1];
    end
  end

endmodule

// File: rtl/misc_stat_resp.sv
module misc_stat_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              size_ok,
  input  logic              rd_dir_ev,
  input  logic [DATA_W-1:0] value,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !size_ok;
      rsp_rdata <= rd_dir_ev ? value : '0;
    end
  end

endmodule

// File: rtl/misc_stat_reg.sv
module misc_stat_reg
  import misc_stat_pkg::*;
#(
  parameter int             ADDR_W       = 32,
  parameter int             DATA_W       = 64,
  parameter int             IMPL_W       = 16,
  parameter int             SIZE_W       = 4,
  parameter alias_variant_e VARIANT      = VAR_AND_OR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              irq
);

  localparam int ACCESS_BYTES = DATA_W / 8;

  logic              size_ok;
  wr_op_e            wr_op;
  logic              wr_ev;
  logic              rd_dir_ev;
  logic              unimpl_ev;
  logic [DATA_W-1:0] cur_value;

  misc_stat_decode #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .ACCESS_BYTES(ACCESS_BYTES),
    .VARIANT     (VARIANT)
  ) u_decode (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_size (req_size),
    .size_ok  (size_ok),
    .wr_op    (wr_op),
    .wr_ev    (wr_ev),
    .rd_dir_ev(rd_dir_ev),
    .unimpl_ev(unimpl_ev)
  );

  misc_stat_store #(
    .DATA_W(DATA_W),
    .IMPL_W(IMPL_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_ev(wr_ev),
    .wr_op(wr_op),
    .wdata(req_wdata),
    .value(cur_value),
    .irq  (irq)
  );

  misc_stat_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .size_ok  (size_ok),
    .rd_dir_ev(rd_dir_ev),
    .value    (cur_value),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
  );

endmodule

// File: rtl/misc_stat_chk.sv
module misc_stat_chk #(
  parameter int DATA_W       = 64,
  parameter int IMPL_W       = 16,
  parameter int SIZE_W       = 4,
  parameter int ACCESS_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [SIZE_W-1:0] req_size,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              irq,
  input logic [DATA_W-1:0] cur_value,
  input logic              rd_dir_ev,
  input logic              unimpl_ev
);

  logic bad_size;
  assign bad_size = req_valid && (req_size != SIZE_W'(ACCESS_BYTES));

  // R9
  irq_follows_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == cur_value[DATA_W-1]);

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_value[DATA_W-IMPL_W-1:0] == '0);

  // R8
  bad_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size |=> $stable(cur_value));

  // R8
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size |=> rsp_err);

  // R6
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R6
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R6
  nondirect_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rd_dir_ev)) |-> (rsp_rdata == '0));

  // R7
  unimpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unimpl_ev && req_write) |=> $stable(cur_value));

endmodule

bind misc_stat_reg misc_stat_chk #(
  .DATA_W      (DATA_W),
  .IMPL_W      (IMPL_W),
  .SIZE_W      (SIZE_W),
  .ACCESS_BYTES(ACCESS_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .irq      (irq),
  .cur_value(cur_value),
  .rd_dir_ev(rd_dir_ev),
  .unimpl_ev(unimpl_ev)
);

// File: tb/test_misc_stat_reg.sv
`timescale 1ns/1ps
module test_misc_stat_reg;
  import misc_stat_pkg::*;

  localparam logic [63:0] MASK = 64'hFFFF_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;

  logic        vld_a, err_a, irq_a, vld_b, err_b, irq_b;
  logic [63:0] rd_a, rd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] exp_a = '0;
  logic [63:0] exp_b = '0;

  always #4 clk = ~clk;

  misc_stat_reg #(.VARIANT(VAR_AND_OR)) i_misc_stat_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(vld_a), .rsp_rdata(rd_a), .rsp_err(err_a), .irq(irq_a));

  misc_stat_reg #(.VARIANT(VAR_CLR_OR)) i_misc_stat_reg_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(vld_b), .rsp_rdata(rd_b), .rsp_err(err_b), .irq(irq_b));

  function automatic logic [31:0] base_of(bit var_b);
    return var_b ? 32'h6080 : 32'h4020;
  endfunction

  // Stored word after one request, restated from R2..R5, R7, R8
  function automatic logic [63:0] model_next(bit var_b, logic wr, logic [31:0] addr,
                                             logic [3:0] sz, logic [63:0] cur,
                                             logic [63:0] wd);
    logic [31:0] w;
    w = addr >> 3;
    if (!wr || sz != 4'd8) return cur;
    if (w == base_of(var_b))     return wd & MASK;
    if (w == base_of(var_b) + 1) return var_b ? 64'd0 : (cur & wd & MASK);
    if (w == base_of(var_b) + 2) return (cur | wd) & MASK;
    return cur;
  endfunction

  // Read data expected in the response, from R6 and R8
  function automatic logic [63:0] model_read(bit var_b, logic wr, logic [31:0] addr,
                                             logic [3:0] sz, logic [63:0] cur);
    if (!wr && sz == 4'd8 && (addr >> 3) == base_of(var_b)) return cur;
    return 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request at a falling edge, check everything at the next one
  task automatic access(input string tag, input logic wr, input logic [31:0] addr,
                        input logic [3:0] sz, input logic [63:0] wd);
    logic [63:0] era, erb;
    era = model_read(0, wr, addr, sz, exp_a);
    erb = model_read(1, wr, addr, sz, exp_b);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    exp_a = model_next(0, wr, addr, sz, exp_a, wd);
    exp_b = model_next(1, wr, addr, sz, exp_b, wd);
    check({tag, " R6 valid A"}, {63'd0, vld_a}, 64'd1);
    check({tag, " R6 valid B"}, {63'd0, vld_b}, 64'd1);
    check({tag, " R8 err A"}, {63'd0, err_a}, {63'd0, sz != 4'd8});
    check({tag, " R8 err B"}, {63'd0, err_b}, {63'd0, sz != 4'd8});
    check({tag, " rdata A"}, rd_a, era);
    check({tag, " rdata B"}, rd_b, erb);
    check({tag, " R9 irq A"}, {63'd0, irq_a}, {63'd0, exp_a[63]});
    check({tag, " R9 irq B"}, {63'd0, irq_b}, {63'd0, exp_b[63]});
  endtask

  task automatic read_back(input string tag);
    access({tag, " readback A"}, 1'b0, base_of(0) << 3, 4'd8, 64'd0);
    access({tag, " readback B"}, 1'b0, base_of(1) << 3, 4'd8, 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1 irq A in reset", {63'd0, irq_a}, 64'd0);
    check("R1 valid A in reset", {63'd0, vld_a}, 64'd0);
    check("R1 irq B in reset", {63'd0, irq_b}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid idle", {63'd0, vld_a | vld_b}, 64'd0);
    read_back("R1");

    // R2: direct write masks the low 48 bits, irq rises
    access("R2 load A", 1'b1, 32'h4020 << 3, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    read_back("R2");
    // R3: AND alias clears bit 63, irq falls
    access("R3 and A", 1'b1, 32'h4021 << 3, 4'd8, 64'h0F00_FFFF_FFFF_FFFF);
    read_back("R3");
    // R4: OR alias on both variants
    access("R4 or A", 1'b1, 32'h4022 << 3, 4'd8, 64'h8000_0000_0000_0001);
    access("R4 load B", 1'b1, 32'h6080 << 3, 4'd8, 64'h0012_3456_789A_BCDE);
    access("R4 or B", 1'b1, 32'h6082 << 3, 4'd8, 64'h8001_0000_0000_0000);
    read_back("R4");
    // R9: irq holds with idle bus
    repeat (5) @(negedge clk);
    check("R9 irq A hold", {63'd0, irq_a}, 64'd1);
    check("R9 irq B hold", {63'd0, irq_b}, 64'd1);
    check("R6 no response idle", {63'd0, vld_a | vld_b}, 64'd0);
    // R6: alias reads return zero
    access("R6 alias read A", 1'b0, 32'h4022 << 3, 4'd8, 64'd0);
    access("R6 alias read B", 1'b0, 32'h6081 << 3, 4'd8, 64'd0);
    // R8: bad sizes ignored
    access("R8 short write", 1'b1, 32'h4020 << 3, 4'd4, 64'd0);
    access("R8 short write B", 1'b1, 32'h6081 << 3, 4'd1, 64'd0);
    access("R8 short read", 1'b0, 32'h4020 << 3, 4'd15, 64'd0);
    read_back("R8");
    // R7: unimplemented word addresses
    access("R7 unimpl write", 1'b1, 32'h4023 << 3, 4'd8, 64'd0);
    access("R7 unimpl write2", 1'b1, 32'h607F << 3, 4'd8, 64'd0);
    access("R7 unimpl read", 1'b0, 32'h0000_0000, 4'd8, 64'd0);
    read_back("R7");
    // R5: clear alias ignores its data
    access("R5 clear B", 1'b1, 32'h6081 << 3, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    read_back("R5");
    // R2: low address bits are ignored
    access("R2 unaligned", 1'b1, (32'h4020 << 3) | 32'd5, 4'd8, 64'hA5A5_0000_0000_0000);
    read_back("R2 unaligned");

    // Random mix over the six live words plus strays
    for (int i = 0; i < 600; i++) begin
      int pick;
      pick = int'($urandom % 8);
      case (pick)
        0, 1, 2: a = (32'h4020 + 32'(pick)) << 3;
        3, 4, 5: a = (32'h6080 + 32'(pick - 3)) << 3;
        6:       a = (32'h4020 + 32'($urandom % 8) - 32'd2) << 3;
        default: a = $urandom;
      endcase
      access("R2-mix random", 1'(($urandom % 3) != 0), a,
             (($urandom % 10) == 0) ? 4'($urandom % 16) : 4'd8,
             {$urandom, $urandom});
      if (($urandom % 16) == 0) @(negedge clk);
    end
    read_back("R9 final");
    finish_run();
  end

endmodule